// File: doc/BRIEF.md
# Merged-Chain Collision Locator

This unit takes two walk records, each a starting seed and the number of hash steps the walk took, that are known to end on the same distinguished value. From those two records alone it recovers the pair of distinct inputs that hash to the same output. It does not need any of the intermediate values that the walks produced.

Once two chains reach a common value, every value after it is also common. So the unit first takes the difference of the two step counts. It then advances the longer chain by exactly that difference, so that both chains are the same number of steps from the shared endpoint. After that it steps both chains together. At every step it compares the next hash of each chain. The first step where those hashes agree gives the collision.

The unit also reports when the records hold no collision. This happens when the two current inputs become equal before any hash match, which means one chain is a suffix of the other. It also happens when the shorter count runs out without a match. The hash is a small non-injective function of the input, the same one the walking core uses.

Top module: `chain_collision_locator`

## Requirements
- R1: After reset, `busy`, `done` and `found` are 0.
- R2: A `start` pulse while `busy` is 0 captures both records and raises `busy`. A `start` while `busy` is 1 is ignored: the running job's results are unchanged.
- R3: Before any comparison, the chain with the larger count (A when `cnt_a` > `cnt_b`, otherwise B) is advanced by exactly |`cnt_a` − `cnt_b`| hash steps. The other chain is not advanced.
- R4: When `found` is 1 at `done`, `pair_a` differs from `pair_b`, and hash(`pair_a`) = hash(`pair_b`) = `pair_hash`.
- R5: The reported pair is the first aligned step, counted from alignment, at which the next hashes of the two chains agree. `pair_a` is taken from chain A and `pair_b` from chain B.
- R6: If the two current aligned inputs are equal before any hash match, the job ends with `found` = 0 and `pair_a` = `pair_b` = `pair_hash` = 0.
- R7: After alignment, at most min(`cnt_a`, `cnt_b`) lockstep steps are taken. If no match has occurred by then, the job ends with `found` = 0 and all result fields 0.
- R8: `done` is a single-cycle pulse. `busy` falls on the same clock edge on which `done` rises. `found` and the result fields hold their values until the next accepted `start`.
- R9: The hash is h(x) = (x·x mod 2^W) XOR KEY.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job with the presented records |
| seed_a | input | W | Seed of walk record A |
| cnt_a | input | C | Step count of walk record A |
| seed_b | input | W | Seed of walk record B |
| cnt_b | input | C | Step count of walk record B |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| found | output | 1 | The job located a collision |
| pair_a | output | W | Colliding input from chain A |
| pair_b | output | W | Colliding input from chain B |
| pair_hash | output | W | Common hash of the pair |

## Verification
The bench builds the block with W = 8, C = 8 and KEY = 0x5B. With an 8-bit squaring hash, x and 256 − x always collide, so merging chains are easy to construct directly. Short walks also fall into cycles often, which brings the suffix-chain and exhausted-bound endings within reach. An 8-bit count keeps even the largest alignment runs to a few hundred cycles. This allows a sweep over many seed and count pairs, in both orders of the longer chain.

// File: rtl/clc_pkg.sv
package clc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_WALK  = 2'd2
    } clc_state_e;
endpackage

// File: rtl/clc_hash.sv
module clc_hash #(
    parameter int          W   = 8,
    parameter logic [W-1:0] KEY = '0
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] h
);
    localparam int SQW = 2 * W;
    logic [SQW-1:0] sq;

    always_comb begin
        sq = {{W{1'b0}}, x} * {{W{1'b0}}, x};
        h  = sq[W-1:0] ^ KEY;
    end
endmodule

// File: rtl/clc_count_order.sv
module clc_count_order #(
    parameter int C = 8
) (
    input  logic [C-1:0] ca,
    input  logic [C-1:0] cb,
    output logic         a_longer,
    output logic [C-1:0] diff,
    output logic [C-1:0] shorter
);
    always_comb begin
        a_longer = (ca > cb);
        diff     = a_longer ? (ca - cb) : (cb - ca);
        shorter  = a_longer ? cb : ca;
    end
endmodule

// File: rtl/chain_collision_locator.sv
module chain_collision_locator #(
    parameter int          W   = 8,
    parameter int          C   = 8,
    parameter logic [W-1:0] KEY = 8'h5B
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] seed_a,
    input  logic [C-1:0] cnt_a,
    input  logic [W-1:0] seed_b,
    input  logic [C-1:0] cnt_b,
    output logic         busy,
    output logic         done,
    output logic         found,
    output logic [W-1:0] pair_a,
    output logic [W-1:0] pair_b,
    output logic [W-1:0] pair_hash
);
    import clc_pkg::*;

    localparam int NCH = 2;

    typedef struct packed {
        clc_state_e   state;
        logic [W-1:0] xa;
        logic [W-1:0] xb;
        logic [C-1:0] diff;
        logic         adv_a;
        logic [C-1:0] bound;
        logic [C-1:0] iter;
        logic         done;
        logic         found;
        logic [W-1:0] res_a;
        logic [W-1:0] res_b;
        logic [W-1:0] res_h;
    } regs_t;

    regs_t r_q, r_d;

    logic [W-1:0] cur   [NCH];
    logic [W-1:0] nxt   [NCH];
    logic         a_longer;
    logic [C-1:0] cnt_diff;
    logic [C-1:0] cnt_short;

    assign cur[0] = r_q.xa;
    assign cur[1] = r_q.xb;

    for (genvar g = 0; g < NCH; g++) begin : g_hash
        clc_hash #(.W(W), .KEY(KEY)) i_hash (
            .x (cur[g]),
            .h (nxt[g])
        );
    end

    clc_count_order #(.C(C)) i_order (
        .ca       (cnt_a),
        .cb       (cnt_b),
        .a_longer (a_longer),
        .diff     (cnt_diff),
        .shorter  (cnt_short)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state = ST_ALIGN;
                    r_d.xa    = seed_a;
                    r_d.xb    = seed_b;
                    r_d.diff  = cnt_diff;
                    r_d.adv_a = a_longer;
                    r_d.bound = cnt_short;
                    r_d.iter  = '0;
                    r_d.found = 1'b0;
                    r_d.res_a = '0;
                    r_d.res_b = '0;
                    r_d.res_h = '0;
                end
            end
            ST_ALIGN: begin
                if (r_q.diff == '0) begin
                    r_d.state = ST_WALK;
                end else begin
                    r_d.diff = r_q.diff - 1'b1;
                    if (r_q.adv_a) r_d.xa = nxt[0];
                    else           r_d.xb = nxt[1];
                end
            end
            ST_WALK: begin
                if (r_q.xa == r_q.xb || r_q.iter == r_q.bound) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.found = 1'b0;
                end else if (nxt[0] == nxt[1]) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.found = 1'b1;
                    r_d.res_a = r_q.xa;
                    r_d.res_b = r_q.xb;
                    r_d.res_h = nxt[0];
                end else begin
                    r_d.xa   = nxt[0];
                    r_d.xb   = nxt[1];
                    r_d.iter = r_q.iter + 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.state != ST_IDLE);
    assign done      = r_q.done;
    assign found     = r_q.found;
    assign pair_a    = r_q.res_a;
    assign pair_b    = r_q.res_b;
    assign pair_hash = r_q.res_h;

    function automatic logic [W-1:0] ref_hash(input logic [W-1:0] v);
        logic [2*W-1:0] p;
        p = {{W{1'b0}}, v} * {{W{1'b0}}, v};
        return p[W-1:0] ^ KEY;
    endfunction

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_pair_distinct_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (pair_a != pair_b));
    assert_pair_hash_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (ref_hash(pair_a) == pair_hash && ref_hash(pair_b) == pair_hash));
    assert_nocoll_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> (pair_a == '0 && pair_b == '0 && pair_hash == '0));
    assert_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WALK) |-> (r_q.diff == '0));
    assert_step_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WALK) |-> (r_q.iter <= r_q.bound));
    assert_no_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(r_q.bound) && $stable(r_q.adv_a)));
endmodule

// File: tb/test_chain_collision_locator.sv
`timescale 1ns/1ps
module test_chain_collision_locator;
    localparam int          W   = 8;
    localparam int          C   = 8;
    localparam logic [W-1:0] KEY = 8'h5B;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] seed_a = '0, seed_b = '0;
    logic [C-1:0] cnt_a = '0, cnt_b = '0;
    logic         busy, done, found;
    logic [W-1:0] pair_a, pair_b, pair_hash;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    chain_collision_locator #(.W(W), .C(C), .KEY(KEY)) i_chain_collision_locator (
        .clk, .rst_n, .start, .seed_a, .cnt_a, .seed_b, .cnt_b,
        .busy, .done, .found, .pair_a, .pair_b, .pair_hash
    );

    function automatic logic [W-1:0] hf(input logic [W-1:0] v);
        logic [2*W-1:0] p;
        p = {{W{1'b0}}, v} * {{W{1'b0}}, v};
        return p[W-1:0] ^ KEY;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // expected result: step longer chain by the count difference, then lockstep
    task automatic expect_job(input logic [W-1:0] sa, input int ca, input logic [W-1:0] sb, input int cb,
                              output bit f, output logic [W-1:0] ea, output logic [W-1:0] eb,
                              output logic [W-1:0] eh);
        logic [W-1:0] x, y;
        int lim;
        x = sa; y = sb; f = 0; ea = '0; eb = '0; eh = '0;
        if (ca > cb) begin for (int i = 0; i < ca - cb; i++) x = hf(x); lim = cb; end
        else         begin for (int i = 0; i < cb - ca; i++) y = hf(y); lim = ca; end
        for (int k = 0; k <= lim; k++) begin
            if (x == y || k == lim) break;
            if (hf(x) == hf(y)) begin f = 1; ea = x; eb = y; eh = hf(x); break; end
            x = hf(x); y = hf(y);
        end
    endtask

    task automatic launch(input logic [W-1:0] sa, input int ca, input logic [W-1:0] sb, input int cb);
        @(negedge clk);
        seed_a = sa; cnt_a = C'(ca); seed_b = sb; cnt_b = C'(cb); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        chk(req, "done seen", int'(done), 1);
    endtask

    task automatic run_case(input string req, input logic [W-1:0] sa, input int ca,
                            input logic [W-1:0] sb, input int cb);
        bit f; logic [W-1:0] ea, eb, eh;
        expect_job(sa, ca, sb, cb, f, ea, eb, eh);
        launch(sa, ca, sb, cb);
        chk("R2", "busy after start", int'(busy), 1);
        wait_done(req);
        chk("R8", "busy low at done", int'(busy), 0);
        chk(req, "found", int'(found), int'(f));
        chk(req, "pair_a", int'(pair_a), int'(ea));
        chk(req, "pair_b", int'(pair_b), int'(eb));
        chk(req, "pair_hash", int'(pair_hash), int'(eh));
        if (found) begin
            chk("R4", "distinct pair", int'(pair_a != pair_b), 1);
            chk("R9", "hash of pair_a", int'(hf(pair_a)), int'(pair_hash));
            chk("R9", "hash of pair_b", int'(hf(pair_b)), int'(pair_hash));
        end
        @(negedge clk);
        chk("R8", "done one cycle", int'(done), 0);
        chk("R8", "found held", int'(found), int'(f));
    endtask

    task automatic t_reset();
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "found", int'(found), 0);
    endtask

    task automatic t_direct_pair();
        // R5: 3 and 253 square to the same value mod 256
        run_case("R5", 8'd3, 4, 8'd253, 4);
        chk("R5", "pair_a is 3", int'(pair_a), 3);
        chk("R5", "pair_b is 253", int'(pair_b), 253);
    endtask

    task automatic t_align_a_longer();
        logic [W-1:0] a2;
        a2 = hf(hf(8'h11));
        run_case("R3", 8'h11, 6, 8'(-a2), 4);
    endtask

    task automatic t_align_b_longer();
        logic [W-1:0] a3;
        a3 = hf(hf(hf(8'h27)));
        run_case("R3", 8'(-a3), 2, 8'h27, 5);
    endtask

    task automatic t_suffix();
        logic [W-1:0] s3;
        s3 = hf(hf(hf(8'h35)));
        run_case("R6", 8'h35, 5, s3, 2);
        chk("R6", "suffix no collision", int'(found), 0);
        run_case("R6", 8'h44, 3, 8'h44, 3);
        chk("R6", "identical seeds", int'(found), 0);
    endtask

    task automatic t_bound();
        run_case("R7", 8'h01, 0, 8'h02, 0);
        chk("R7", "zero bound", int'(found), 0);
        run_case("R7", 8'h10, 3, 8'h20, 1);
    endtask

    task automatic t_busy_start();
        bit f; logic [W-1:0] ea, eb, eh;
        expect_job(8'd5, 40, 8'd251, 3, f, ea, eb, eh);
        launch(8'd5, 40, 8'd251, 3);
        @(negedge clk);
        seed_a = 8'd9; cnt_a = 8'd1; seed_b = 8'd9; cnt_b = 8'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R2");
        chk("R2", "ignored start found", int'(found), int'(f));
        chk("R2", "ignored start pair_a", int'(pair_a), int'(ea));
        chk("R2", "ignored start pair_b", int'(pair_b), int'(eb));
        @(negedge clk);
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 24; i++) begin
            logic [W-1:0] sa, sb;
            sa = 8'(i * 37 + 1);
            sb = (i % 3 == 0) ? 8'(-sa) : 8'(i * 91 + 7);
            run_case("R5", sa, (i * 7) % 11, sb, (i * 5) % 13);
        end
    endtask

    initial begin
        while (cycles < 100000) begin @(posedge clk); cycles++; end
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct_pair();
        t_align_a_longer();
        t_align_b_longer();
        t_suffix();
        t_bound();
        t_busy_start();
        t_sweep();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule